// File: doc/BRIEF.md
# Receive DMA Port Mover

This block sits between a set of per-port receive FIFOs and a shared frame buffer memory with a 64-bit data path. Each clock it picks one port that has data waiting and moves a single memory word from that port's FIFO into the buffer. A full word is eight bytes. The last word of a frame may hold fewer bytes, and a byte-enable mask marks which of its bytes are valid. Every frame gets a buffer handle when its first word is moved. The handle comes from a free-handle counter that never runs dry. Each word is written at the frame's handle base plus the word's position within the frame.

While a frame is being moved, the block keeps a copy of its opening 64 bytes. That span includes both MAC addresses. When the final word arrives with a good end-of-frame status, the block raises a switch request for that port. The request carries the handle, the frame length in words and the saved header. A frame that ends with a bad status produces no request. Its handle is released on a one-cycle output instead. Pending requests from all ports are arbitrated round-robin and handed one per cycle to a downstream search stage over a valid/ready handshake.

Top module: `rxdma_mover`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `mem_we`, `rel_valid` and `sreq_valid` are low. With no FIFO data, no `fifo_pop` is raised.
- R2: Each cycle at most one `fifo_pop` bit is high. The chosen port is the first port, counting upward and cyclically from the port served last, that has `fifo_valid` set and no pending switch request. Ports without data are skipped without costing a cycle. After reset the search starts at port 0.
- R3: The cycle after a pop, `mem_we` is high. `mem_wdata` then equals the popped word, and `mem_addr` equals `{handle, word_offset}`, where the offset counts the frame's words from 0. A cycle with no pop gives `mem_we` low in the following cycle.
- R4: `mem_be` bit i enables byte i (bits 8i+7..8i). A word without end-of-frame has all bits set. On an end-of-frame word whose `fifo_nbytes` value is k, only bits 0..k are set, so k+1 bytes are valid.
- R5: A frame's handle is the value of a free-handle counter that starts at 0 after reset. The counter advances by one, modulo 2^HANDLE_W, at each frame's first word, and the handle stays fixed for the whole frame.
- R6: The cycle after a good end-of-frame word is popped, the port has a pending request. `sreq_handle` and `sreq_words` (the frame length in words) are presented whenever that port is selected.
- R7: `sreq_hdr` holds the frame's first HDR_WORDS words, with word i in bits 64i+63..64i. Bytes disabled by the final word's mask, and all words past the end of a shorter frame, read as zero.
- R8: A bad end-of-frame word produces no request. The next cycle, `rel_valid` pulses for one cycle, with `rel_handle` carrying the frame's handle.
- R9: A port with a pending request is not popped until that request has been accepted.
- R10: Pending requests are chosen round-robin, counting upward from the port accepted last. Once `sreq_valid` is shown with `sreq_ready` low, the port, handle and length stay unchanged until accepted. One request is accepted per cycle in which both `sreq_valid` and `sreq_ready` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_valid | input | NPORTS | Per-port FIFO holds a word |
| fifo_data | input | NPORTS*DATA_W | Per-port head word |
| fifo_eof | input | NPORTS | Head word is the last of its frame |
| fifo_good | input | NPORTS | End-of-frame status is good (meaningful with eof) |
| fifo_nbytes | input | NPORTS*3 | Valid bytes minus one on an end-of-frame word |
| fifo_pop | output | NPORTS | Removes the head word of the selected port |
| mem_we | output | 1 | Buffer memory write strobe |
| mem_addr | output | HANDLE_W+OFFSET_W | Write address {handle, word offset} |
| mem_wdata | output | DATA_W | Write data |
| mem_be | output | DATA_W/8 | Byte enables |
| rel_valid | output | 1 | Handle of a bad frame is returned |
| rel_handle | output | HANDLE_W | Returned handle |
| sreq_valid | output | 1 | Switch request offered |
| sreq_ready | input | 1 | Downstream accepts the request |
| sreq_port | output | 2 | Port of the offered request |
| sreq_handle | output | HANDLE_W | Buffer handle of the frame |
| sreq_words | output | OFFSET_W+1 | Frame length in words |
| sreq_hdr | output | HDR_WORDS*DATA_W | Opening bytes of the frame |

## Verification
The bench goes after frames of one word, frames with a partial last word, and frames longer than the header window. A design with a wrong mask or a missing clear would leak stale bytes into `sreq_hdr`, or set the wrong `mem_be` bits. It runs enough frames that the handle counter wraps and mixes bad frames among good ones, which exposes an allocator that skips or reuses values and a release that fires on good frames. It also holds `sreq_ready` low while several ports finish frames. A design that let a pending port keep moving would overwrite the header under an unaccepted request. One that re-arbitrated while stalled would change `sreq_port` before the handshake.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
   localparam int MAX_BYTES = 64;

   // Bits below position n set, all others clear.
   function automatic logic [MAX_BYTES-1:0] lsb_mask(input int n);
      logic [MAX_BYTES-1:0] r;
      for (int i = 0; i < MAX_BYTES; i++) r[i] = (i < n);
      return r;
   endfunction
endpackage

// File: rtl/rxdma_rr_pick.sv
module rxdma_rr_pick #(
   parameter int N  = 4,
   parameter int IW = 2
) (
   input  logic [N-1:0]  req,
   input  logic [IW-1:0] last,
   output logic          any,
   output logic [IW-1:0] idx
);
   generate
      if (N == 1) begin : g_single
         logic unused_last;
         assign unused_last = ^last;
         assign any = req[0];
         assign idx = '0;
      end else begin : g_multi
         always_comb begin
            any = 1'b0;
            idx = last;
            for (int k = 1; k <= N; k++) begin
               if (!any && req[(int'(last) + k) % N]) begin
                  any = 1'b1;
                  idx = IW'((int'(last) + k) % N);
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/rxdma_port_ctx.sv
module rxdma_port_ctx
   import rxdma_pkg::*;
#(
   parameter int DATA_W    = 64,
   parameter int HDR_WORDS = 8,
   parameter int HANDLE_W  = 4,
   parameter int OFFSET_W  = 6
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          sel,
   input  logic [DATA_W-1:0]             data,
   input  logic                          eof,
   input  logic                          good,
   input  logic [$clog2(DATA_W/8)-1:0]   nbytes,
   input  logic [HANDLE_W-1:0]           alloc_handle,
   input  logic                          clr,
   output logic                          pend,
   output logic                          active,
   output logic [HANDLE_W-1:0]           cur_handle,
   output logic [OFFSET_W-1:0]           cur_off,
   output logic [DATA_W/8-1:0]           word_be,
   output logic [HANDLE_W-1:0]           req_handle,
   output logic [OFFSET_W:0]             req_words,
   output logic [HDR_WORDS*DATA_W-1:0]   hdr
);
   localparam int BYTES = DATA_W / 8;

   logic [HANDLE_W-1:0]  hnd_q;
   logic [OFFSET_W-1:0]  off_q;
   logic                 act_q, pend_q;
   logic [DATA_W-1:0]    kept;
   logic [MAX_BYTES-1:0] tail_m;
   logic [DATA_W-1:0]    hdr_q [HDR_WORDS];

   always_comb begin
      tail_m  = lsb_mask(int'(nbytes) + 1);
      word_be = eof ? tail_m[BYTES-1:0] : '1;
      for (int b = 0; b < BYTES; b++)
         kept[b*8 +: 8] = word_be[b] ? data[b*8 +: 8] : 8'h00;
   end

   assign cur_handle = act_q ? hnd_q : alloc_handle;
   assign cur_off    = off_q;
   assign pend       = pend_q;
   assign active     = act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hnd_q      <= '0;
         off_q      <= '0;
         act_q      <= 1'b0;
         pend_q     <= 1'b0;
         req_handle <= '0;
         req_words  <= '0;
      end else begin
         if (clr) pend_q <= 1'b0;
         if (sel) begin
            if (!act_q) hnd_q <= alloc_handle;
            if (eof) begin
               act_q <= 1'b0;
               off_q <= '0;
               if (good) begin
                  pend_q     <= 1'b1;
                  req_handle <= cur_handle;
                  req_words  <= {1'b0, off_q} + 1'b1;
               end
            end else begin
               act_q <= 1'b1;
               off_q <= off_q + 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int w = 0; w < HDR_WORDS; w++) hdr_q[w] <= '0;
      end else if (sel) begin
         for (int w = 0; w < HDR_WORDS; w++) begin
            if (off_q == OFFSET_W'(w)) hdr_q[w] <= kept;
            else if (!act_q)           hdr_q[w] <= '0;
         end
      end
   end

   generate
      for (genvar w = 0; w < HDR_WORDS; w++) begin : g_hdr
         assign hdr[w*DATA_W +: DATA_W] = hdr_q[w];
      end
   endgenerate
endmodule

// File: rtl/rxdma_mover.sv
module rxdma_mover
   import rxdma_pkg::*;
#(
   parameter int NPORTS    = 4,
   parameter int DATA_W    = 64,
   parameter int HDR_WORDS = 8,
   parameter int HANDLE_W  = 4,
   parameter int OFFSET_W  = 6
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic [NPORTS-1:0]                     fifo_valid,
   input  logic [NPORTS*DATA_W-1:0]              fifo_data,
   input  logic [NPORTS-1:0]                     fifo_eof,
   input  logic [NPORTS-1:0]                     fifo_good,
   input  logic [NPORTS*$clog2(DATA_W/8)-1:0]    fifo_nbytes,
   output logic [NPORTS-1:0]                     fifo_pop,
   output logic                                  mem_we,
   output logic [HANDLE_W+OFFSET_W-1:0]          mem_addr,
   output logic [DATA_W-1:0]                     mem_wdata,
   output logic [DATA_W/8-1:0]                   mem_be,
   output logic                                  rel_valid,
   output logic [HANDLE_W-1:0]                   rel_handle,
   output logic                                  sreq_valid,
   input  logic                                  sreq_ready,
   output logic [(NPORTS>1 ? $clog2(NPORTS) : 1)-1:0] sreq_port,
   output logic [HANDLE_W-1:0]                   sreq_handle,
   output logic [OFFSET_W:0]                     sreq_words,
   output logic [HDR_WORDS*DATA_W-1:0]           sreq_hdr
);
   localparam int BYTES  = DATA_W / 8;
   localparam int CNT_W  = $clog2(BYTES);
   localparam int PORT_W = NPORTS > 1 ? $clog2(NPORTS) : 1;
   localparam int HDR_W  = HDR_WORDS * DATA_W;

   generate
      if (DATA_W % 8 != 0 || DATA_W < 16 || BYTES > MAX_BYTES) begin : g_bad_width
         $error("rxdma_mover: DATA_W must be a byte multiple between 16 and 512");
      end
      if (HDR_WORDS < 1 || HDR_WORDS > (1 << OFFSET_W)) begin : g_bad_hdr
         $error("rxdma_mover: header window must fit in one frame");
      end
      if (NPORTS < 1) begin : g_bad_ports
         $error("rxdma_mover: at least one port required");
      end
   endgenerate

   logic [NPORTS-1:0]   avail, grant_oh, pend, active;
   logic [PORT_W-1:0]   g_idx, g_last, r_idx, r_last, held_q, r_sel;
   logic                g_any, r_any, hold_q, accept;
   logic [HANDLE_W-1:0] alloc_q;
   logic [HANDLE_W-1:0] cur_hnd [NPORTS];
   logic [OFFSET_W-1:0] cur_off [NPORTS];
   logic [BYTES-1:0]    be_a    [NPORTS];
   logic [HANDLE_W-1:0] req_hnd [NPORTS];
   logic [OFFSET_W:0]   req_wds [NPORTS];
   logic [HDR_W-1:0]    hdr_a   [NPORTS];

   assign avail = fifo_valid & ~pend;

   rxdma_rr_pick #(.N(NPORTS), .IW(PORT_W)) u_svc_pick (
      .req(avail), .last(g_last), .any(g_any), .idx(g_idx));

   assign grant_oh = g_any ? (NPORTS'(1) << g_idx) : '0;
   assign fifo_pop = grant_oh;

   rxdma_rr_pick #(.N(NPORTS), .IW(PORT_W)) u_req_pick (
      .req(pend), .last(r_last), .any(r_any), .idx(r_idx));

   assign r_sel  = hold_q ? held_q : r_idx;
   assign accept = r_any & sreq_ready;

   generate
      for (genvar p = 0; p < NPORTS; p++) begin : g_port
         rxdma_port_ctx #(
            .DATA_W(DATA_W), .HDR_WORDS(HDR_WORDS),
            .HANDLE_W(HANDLE_W), .OFFSET_W(OFFSET_W)
         ) u_ctx (
            .clk          (clk),
            .rst_n        (rst_n),
            .sel          (grant_oh[p]),
            .data         (fifo_data[p*DATA_W +: DATA_W]),
            .eof          (fifo_eof[p]),
            .good         (fifo_good[p]),
            .nbytes       (fifo_nbytes[p*CNT_W +: CNT_W]),
            .alloc_handle (alloc_q),
            .clr          (accept && (r_sel == PORT_W'(p))),
            .pend         (pend[p]),
            .active       (active[p]),
            .cur_handle   (cur_hnd[p]),
            .cur_off      (cur_off[p]),
            .word_be      (be_a[p]),
            .req_handle   (req_hnd[p]),
            .req_words    (req_wds[p]),
            .hdr          (hdr_a[p])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_we     <= 1'b0;
         mem_addr   <= '0;
         mem_wdata  <= '0;
         mem_be     <= '0;
         rel_valid  <= 1'b0;
         rel_handle <= '0;
         alloc_q    <= '0;
         g_last     <= PORT_W'(NPORTS - 1);
         r_last     <= PORT_W'(NPORTS - 1);
         hold_q     <= 1'b0;
         held_q     <= '0;
      end else begin
         mem_we    <= g_any;
         rel_valid <= g_any && fifo_eof[g_idx] && !fifo_good[g_idx];
         if (g_any) begin
            mem_addr  <= {cur_hnd[g_idx], cur_off[g_idx]};
            mem_wdata <= fifo_data[g_idx*DATA_W +: DATA_W];
            mem_be    <= be_a[g_idx];
            g_last    <= g_idx;
            if (!active[g_idx]) alloc_q <= alloc_q + 1'b1;
            if (fifo_eof[g_idx] && !fifo_good[g_idx]) rel_handle <= cur_hnd[g_idx];
         end
         if (r_any && !sreq_ready) begin
            hold_q <= 1'b1;
            held_q <= r_sel;
         end else if (accept) begin
            hold_q <= 1'b0;
            r_last <= r_sel;
         end
      end
   end

   assign sreq_valid  = r_any;
   assign sreq_port   = r_sel;
   assign sreq_handle = req_hnd[r_sel];
   assign sreq_words  = req_wds[r_sel];
   assign sreq_hdr    = hdr_a[r_sel];
endmodule

// File: rtl/rxdma_mover_chk.sv
module rxdma_mover_chk #(
   parameter int NPORTS    = 4,
   parameter int DATA_W    = 64,
   parameter int HDR_WORDS = 8,
   parameter int HANDLE_W  = 4,
   parameter int OFFSET_W  = 6
) (
   input logic                                  clk,
   input logic                                  rst_n,
   input logic [NPORTS-1:0]                     fifo_valid,
   input logic [NPORTS*DATA_W-1:0]              fifo_data,
   input logic [NPORTS-1:0]                     fifo_eof,
   input logic [NPORTS-1:0]                     fifo_good,
   input logic [NPORTS*$clog2(DATA_W/8)-1:0]    fifo_nbytes,
   input logic [NPORTS-1:0]                     fifo_pop,
   input logic                                  mem_we,
   input logic [HANDLE_W+OFFSET_W-1:0]          mem_addr,
   input logic [DATA_W-1:0]                     mem_wdata,
   input logic [DATA_W/8-1:0]                   mem_be,
   input logic                                  rel_valid,
   input logic [HANDLE_W-1:0]                   rel_handle,
   input logic                                  sreq_valid,
   input logic                                  sreq_ready,
   input logic [(NPORTS>1 ? $clog2(NPORTS) : 1)-1:0] sreq_port,
   input logic [HANDLE_W-1:0]                   sreq_handle,
   input logic [OFFSET_W:0]                     sreq_words,
   input logic [HDR_WORDS*DATA_W-1:0]           sreq_hdr
);
   localparam int BYTES = DATA_W / 8;

   assert_pop_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(fifo_pop));

   assert_pop_needs_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_pop & ~fifo_valid) == '0);

   assert_write_follows_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (|fifo_pop) |=> mem_we);

   assert_idle_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(|fifo_pop) |=> !mem_we);

   assert_be_contiguous_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_be[0] && ((({1'b0, mem_be} + 1'b1) & {1'b0, mem_be}) == '0)));

   assert_full_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (|(fifo_pop & ~fifo_eof)) |=> (mem_be == {BYTES{1'b1}}));

   assert_release_only_bad_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rel_valid |-> $past(|(fifo_pop & fifo_eof & ~fifo_good)));

   assert_no_pop_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sreq_valid |-> !fifo_pop[sreq_port]);

   assert_hold_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (sreq_valid && !sreq_ready) |=> (sreq_valid && $stable(sreq_port)
                                       && $stable(sreq_handle) && $stable(sreq_words)));
endmodule

bind rxdma_mover rxdma_mover_chk #(
   .NPORTS(NPORTS), .DATA_W(DATA_W), .HDR_WORDS(HDR_WORDS),
   .HANDLE_W(HANDLE_W), .OFFSET_W(OFFSET_W)
) u_chk (.*);

// File: tb/test_rxdma_mover.sv
`timescale 1ns/1ps
module test_rxdma_mover;
   localparam int NP = 4;
   localparam int DW = 64;
   localparam int HW = 8;
   localparam int HNDW = 4;
   localparam int OFW = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NP-1:0]    fifo_valid = '0;
   logic [NP*DW-1:0] fifo_data = '0;
   logic [NP-1:0]    fifo_eof = '0;
   logic [NP-1:0]    fifo_good = '0;
   logic [NP*3-1:0]  fifo_nbytes = '0;
   logic [NP-1:0]    fifo_pop;
   logic             mem_we;
   logic [9:0]       mem_addr;
   logic [63:0]      mem_wdata;
   logic [7:0]       mem_be;
   logic             rel_valid;
   logic [3:0]       rel_handle;
   logic             sreq_valid;
   logic             sreq_ready = 1'b0;
   logic [1:0]       sreq_port;
   logic [3:0]       sreq_handle;
   logic [6:0]       sreq_words;
   logic [511:0]     sreq_hdr;

   always #2.5 clk = ~clk;

   rxdma_mover i_rxdma_mover (.*);

   int tests = 0;
   int fails = 0;
   bit done = 0;
   int cyc = 0;
   int ready_mode = 1;

   // bench FIFOs: [68:5] data, [4] eof, [3] good, [2:0] byte count minus one
   logic [68:0] fq [NP][$];

   // reference state
   bit          mact [NP];
   int          mhnd [NP];
   int          moff [NP];
   bit          mpend [NP];
   int          mrh [NP];
   int          mrw [NP];
   logic [511:0] mhdr [NP];
   int gptr = NP - 1, rptr = NP - 1, alloc = 0, mheld = 0;
   bit mhold = 0;
   bit ex_we = 0, ex_rel = 0;
   logic [9:0] ex_addr; logic [63:0] ex_data; logic [7:0] ex_be; int ex_relh;

   task automatic chk(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%0h exp=%0h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   function automatic logic [63:0] gen_word(int p, int fid, int w);
      return {8'(p), 8'(fid), 16'(w), 32'(fid * 977 + w * 31 + p * 7 + 32'h5A00_0000)};
   endfunction

   int fid_ctr = 0;
   task automatic push_frame(int p, int nwords, int lastcnt, bit good);
      fid_ctr++;
      for (int w = 0; w < nwords; w++) begin
         bit last = (w == nwords - 1);
         fq[p].push_back({gen_word(p, fid_ctr, w), last, good, 3'(last ? lastcnt : 7)});
      end
   endtask

   task automatic cycle();
      int g;
      bit any;
      int ch;
      @(negedge clk);
      cyc++;
      // registered outputs from the previous edge
      chk(mem_we == ex_we, "R3 mem_we", 512'(mem_we), 512'(ex_we));
      if (ex_we) begin
         chk(mem_addr == ex_addr, "R3/R5 mem_addr", 512'(mem_addr), 512'(ex_addr));
         chk(mem_wdata == ex_data, "R3 mem_wdata", 512'(mem_wdata), 512'(ex_data));
         chk(mem_be == ex_be, "R4 mem_be", 512'(mem_be), 512'(ex_be));
      end
      chk(rel_valid == ex_rel, "R8 rel_valid", 512'(rel_valid), 512'(ex_rel));
      if (ex_rel) chk(rel_handle == 4'(ex_relh), "R8 rel_handle", 512'(rel_handle), 512'(ex_relh));
      // drive this cycle's inputs
      for (int p = 0; p < NP; p++) begin
         if (fq[p].size() > 0) begin
            fifo_valid[p] = 1'b1;
            fifo_data[p*DW +: DW] = fq[p][0][68:5];
            fifo_eof[p] = fq[p][0][4];
            fifo_good[p] = fq[p][0][3];
            fifo_nbytes[p*3 +: 3] = fq[p][0][2:0];
         end else begin
            fifo_valid[p] = 1'b0;
            fifo_eof[p] = 1'b0;
            fifo_good[p] = 1'b0;
         end
      end
      sreq_ready = (ready_mode == 1) || (ready_mode == 2 && (cyc % 3 != 0));
      #1;
      // service choice
      g = -1;
      for (int k = 1; k <= NP; k++) begin
         int j = (gptr + k) % NP;
         if (g < 0 && fq[j].size() > 0 && !mpend[j]) g = j;
      end
      chk(fifo_pop == (g >= 0 ? NP'(1) << g : NP'(0)), "R2/R9 fifo_pop", 512'(fifo_pop),
          512'(g >= 0 ? NP'(1) << g : NP'(0)));
      // request side
      any = 0;
      for (int p = 0; p < NP; p++) any |= mpend[p];
      chk(sreq_valid == any, "R6 sreq_valid", 512'(sreq_valid), 512'(any));
      if (any) begin
         ch = -1;
         if (mhold) ch = mheld;
         else for (int k = 1; k <= NP; k++) begin
            int j = (rptr + k) % NP;
            if (ch < 0 && mpend[j]) ch = j;
         end
         chk(sreq_port == 2'(ch), "R10 sreq_port", 512'(sreq_port), 512'(ch));
         chk(sreq_handle == 4'(mrh[ch]), "R6 sreq_handle", 512'(sreq_handle), 512'(mrh[ch]));
         chk(sreq_words == 7'(mrw[ch]), "R6 sreq_words", 512'(sreq_words), 512'(mrw[ch]));
         chk(sreq_hdr == mhdr[ch], "R7 sreq_hdr", sreq_hdr, mhdr[ch]);
         if (sreq_ready) begin
            mpend[ch] = 0; rptr = ch; mhold = 0;
         end else begin
            mhold = 1; mheld = ch;
         end
      end
      // word move
      ex_we = 0; ex_rel = 0;
      if (g >= 0) begin
         logic [68:0] e;
         logic [63:0] d, kept;
         logic [7:0] be;
         e = fq[g].pop_front();
         d = e[68:5];
         if (!mact[g]) begin
            mhnd[g] = alloc;
            alloc = (alloc + 1) % 16;
            mhdr[g] = '0;
         end
         be = e[4] ? 8'((1 << (int'(e[2:0]) + 1)) - 1) : 8'hFF;
         for (int b = 0; b < 8; b++) kept[b*8 +: 8] = be[b] ? d[b*8 +: 8] : 8'h00;
         ex_we = 1;
         ex_addr = 10'(mhnd[g] * 64 + moff[g]);
         ex_data = d;
         ex_be = be;
         if (moff[g] < HW) mhdr[g][64*moff[g] +: 64] = kept;
         if (e[4]) begin
            if (e[3]) begin
               mpend[g] = 1; mrh[g] = mhnd[g]; mrw[g] = moff[g] + 1;
            end else begin
               ex_rel = 1; ex_relh = mhnd[g];
            end
            moff[g] = 0; mact[g] = 0;
         end else begin
            moff[g]++; mact[g] = 1;
         end
         gptr = g;
      end
   endtask

   task automatic run(int n);
      for (int i = 0; i < n; i++) cycle();
   endtask

   function automatic bit idle();
      bit b = 1;
      for (int p = 0; p < NP; p++) if (fq[p].size() > 0 || mpend[p]) b = 0;
      return b;
   endfunction

   initial begin
      for (int p = 0; p < NP; p++) begin
         mact[p] = 0; mhnd[p] = 0; moff[p] = 0; mpend[p] = 0; mrh[p] = 0; mrw[p] = 0; mhdr[p] = '0;
      end
      // R1: reset state
      repeat (3) begin
         @(negedge clk);
         chk(mem_we == 0, "R1 mem_we in reset", 512'(mem_we), 0);
         chk(sreq_valid == 0, "R1 sreq_valid in reset", 512'(sreq_valid), 0);
         chk(rel_valid == 0, "R1 rel_valid in reset", 512'(rel_valid), 0);
         chk(fifo_pop == 0, "R1 fifo_pop with no data", 512'(fifo_pop), 0);
      end
      rst_n = 1'b1;
      run(3);
      // R3 R4 R6 R7: three-word frame, 5 bytes in last word
      push_frame(2, 3, 4, 1);
      run(8);
      // R4 R7: single one-byte frame
      push_frame(0, 1, 0, 1);
      run(5);
      // R2 R7: all ports at once, one longer than the header window
      push_frame(0, 2, 7, 1);
      push_frame(1, 10, 2, 1);
      push_frame(2, 5, 6, 1);
      push_frame(3, 1, 3, 1);
      run(30);
      // R8: bad frame then a good one on the same port
      push_frame(1, 4, 1, 0);
      push_frame(1, 2, 5, 1);
      run(12);
      // R9 R10: downstream stalled while ports finish frames
      ready_mode = 0;
      push_frame(0, 2, 7, 1);
      push_frame(3, 3, 0, 1);
      push_frame(0, 3, 2, 1);
      push_frame(2, 1, 1, 1);
      run(25);
      chk(fq[0].size() == 3, "R9 pending port held back", 512'(fq[0].size()), 3);
      ready_mode = 1;
      run(20);
      // R5 R8 R10: many frames, handle wrap, ready toggling
      ready_mode = 2;
      for (int i = 0; i < 24; i++)
         push_frame(i % NP, 1 + (i * 5) % 11, i % 8, (i % 7) != 3);
      for (int i = 0; i < 2000 && !idle(); i++) cycle();
      chk(idle(), "R10 all requests drained", 512'(idle()), 1);
      ready_mode = 1;
      run(4);
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL watchdog R1-run act=hung exp=finished");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule